// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries single words between two ports that run on unrelated clocks, without putting them into the main queue. Mailbox 1 is loaded from port A and unloaded by port B. Mailbox 2 is loaded from port B and unloaded by port A. Each mailbox has two active-low "full" flags, one in each clock domain. The writer's flag blocks a second deposit until the reader has collected the word. The reader's flag tells it that a word is waiting.

Each port has an enable, a direction bit and a mailbox-select input. When the select is high, the access goes to the mailbox. When it is low, the access goes to the queue path. Port A writes that go to the queue raise a write strobe for the queue. Port B reads that go to the queue raise a read strobe, and port B then shows the queue's output register. Set and clear events cross between the domains as toggles through multi-flop synchronizers. The stored word does not change while a flag is low, so the reader can sample it directly. A static width-mode input trims each stored word to the active port B width.

Top module: `mbx_pair`

## Requirements
- R1: A port A rising edge with `a_en`=1, `a_wr`=1, `a_mb_sel`=1 and `m1_wfull_n`=1 stores `a_wdata` into mailbox 1, and `m1_wfull_n` is 0 right after that edge.
- R2: After a mailbox 1 store, `m1_rfull_n` falls within SYNC_STAGES+1 port B edges. While it is low and `b_mb_sel`=1, `b_rdata` shows the stored word and holds it steady.
- R3: A port B rising edge with `b_en`=1, `b_wr`=0, `b_mb_sel`=1 and `m1_rfull_n`=0 sets `m1_rfull_n` to 1 right after the edge. `m1_wfull_n` returns to 1 within SYNC_STAGES+1 port A edges.
- R4: A mailbox write made while that mailbox's writer-side flag is 0 is ignored. The word later collected is the one stored first. This holds for both mailboxes.
- R5: Mailbox 2 mirrors mailbox 1 in the other direction. A port B write with `b_mb_sel`=1 drives `m2_wfull_n` to 0. `m2_rfull_n` falls within SYNC_STAGES+1 port A edges. A port A read with `a_mb_sel`=1 and `m2_rfull_n`=0 sets `m2_rfull_n` to 1 after the edge. `m2_wfull_n` returns to 1 within SYNC_STAGES+1 port B edges.
- R6: `a_rdata` equals mailbox 2 when `a_mb_sel`=1 and is all zeros when `a_mb_sel`=0.
- R7: `b_rdata` equals `b_fifo_q` when `b_mb_sel`=0.
- R8: `a_fifo_wr`=1 exactly when `a_en`=1, `a_wr`=1 and `a_mb_sel`=0. `b_fifo_rd`=1 exactly when `b_en`=1, `b_wr`=0 and `b_mb_sel`=0. A port B write never raises any queue strobe.
- R9: While `rst_a` and `rst_b` are high together, all four flags go to 1 and both mailboxes clear to zero.
- R10: `b_width` sets the stored width for both mailboxes. 0 or 3 keeps all DATA_W bits, 1 keeps the lower half, and 2 keeps the lower quarter. Bits above the kept part are stored as 0.
- R11: A port B mailbox read while `m1_rfull_n`=1 has no effect. Both mailbox 1 flags stay at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Synchronous active-high reset, port A domain |
| a_en | input | 1 | Port A access enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mb_sel | input | 1 | Port A access goes to the mailbox when 1 |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Mailbox 2 contents when selected, otherwise zero |
| a_fifo_wr | output | 1 | Write strobe toward the queue |
| m1_wfull_n | output | 1 | Mailbox 1 occupied, port A view, active low |
| m2_rfull_n | output | 1 | Mailbox 2 holds mail, port A view, active low |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Synchronous active-high reset, port B domain |
| b_en | input | 1 | Port B access enable |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_mb_sel | input | 1 | Port B access goes to the mailbox when 1 |
| b_width | input | 2 | Static port B width mode |
| b_wdata | input | DATA_W | Port B write data |
| b_fifo_q | input | DATA_W | Queue output register value |
| b_rdata | output | DATA_W | Mailbox 1 or queue output, chosen by `b_mb_sel` |
| b_fifo_rd | output | 1 | Read strobe toward the queue |
| m1_rfull_n | output | 1 | Mailbox 1 holds mail, port B view, active low |
| m2_wfull_n | output | 1 | Mailbox 2 occupied, port B view, active low |

## Verification
The checker covers, on every cycle, the behaviour local to each domain: a flag drops right after an accepted write (R1, R5), a flag rises right after an accepted read (R3, R5), the mailbox word stays steady while it is readable (R2), a port B write raises no queue strobe (R8), and the flags come out of reset high (R9). Some behaviour only the bench scenarios can show. These are the end-to-end crossing delay, the writes dropped while mail is pending, the stored word matching what was sent, the width trimming, and the reads of an empty mailbox. The bench checks them by comparing collected words with a queue of the words it sent and by watching the flags on both sides.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int NUM_SLOTS   = 2;
    localparam int LANE_COUNT  = 4;

    typedef enum logic [1:0] {
        WM_FULL    = 2'd0,
        WM_HALF    = 2'd1,
        WM_QUARTER = 2'd2,
        WM_FULL_B  = 2'd3
    } width_mode_e;

    typedef struct packed {
        logic mail_wr;
        logic mail_rd;
        logic queue_go;
    } port_op_t;

    function automatic int active_lanes(input width_mode_e mode);
        case (mode)
            WM_HALF:    return LANE_COUNT / 2;
            WM_QUARTER: return 1;
            default:    return LANE_COUNT;
        endcase
    endfunction

    // queue_dir: 1 when this port writes into the queue, 0 when it reads from it
    function automatic port_op_t decode_op(input logic en, input logic wr,
                                           input logic mb, input logic queue_dir);
        port_op_t op;
        op.mail_wr  = en & wr & mb;
        op.mail_rd  = en & ~wr & mb;
        op.queue_go = en & ~mb & (wr == queue_dir);
        return op;
    endfunction

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_lane_mask.sv
module mbx_lane_mask
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  width_mode_e        mode,
    output logic [DATA_W-1:0]  keep
);
    localparam int LANE_W = DATA_W / LANE_COUNT;

    int lanes_on;
    assign lanes_on = active_lanes(mode);

    for (genvar ln = 0; ln < LANE_COUNT; ln++) begin : g_lane
        assign keep[ln*LANE_W +: LANE_W] = {LANE_W{(ln < lanes_on)}};
    end
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_w,
    input  logic              rst_w,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full_w_n,
    input  logic              clk_r,
    input  logic              rst_r,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              full_r_n
);
    logic [DATA_W-1:0] word_q;
    logic              post_tog;
    logic              take_tog;
    logic              post_seen_r;
    logic              take_seen_w;

    // writer domain: deposit and post toggle
    always_ff @(posedge clk_w) begin
        if (rst_w) begin
            word_q   <= '0;
            post_tog <= 1'b0;
        end else if (wr_req && full_w_n) begin
            word_q   <= wr_data;
            post_tog <= ~post_tog;
        end
    end

    // reader domain: collect toggle
    always_ff @(posedge clk_r) begin
        if (rst_r) begin
            take_tog <= 1'b0;
        end else if (rd_req && !full_r_n) begin
            take_tog <= ~take_tog;
        end
    end

    mbx_sync #(.STAGES(SYNC_STAGES)) u_post_sync (
        .clk (clk_r),
        .rst (rst_r),
        .d   (post_tog),
        .q   (post_seen_r)
    );

    mbx_sync #(.STAGES(SYNC_STAGES)) u_take_sync (
        .clk (clk_w),
        .rst (rst_w),
        .d   (take_tog),
        .q   (take_seen_w)
    );

    assign full_w_n = (post_tog == take_seen_w);
    assign full_r_n = (post_seen_r == take_tog);
    assign rd_data  = word_q;
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
    import mbx_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              rst_a,
    input  logic              a_en,
    input  logic              a_wr,
    input  logic              a_mb_sel,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_fifo_wr,
    output logic              m1_wfull_n,
    output logic              m2_rfull_n,
    input  logic              clk_b,
    input  logic              rst_b,
    input  logic              b_en,
    input  logic              b_wr,
    input  logic              b_mb_sel,
    input  logic [1:0]        b_width,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic [DATA_W-1:0] b_fifo_q,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_fifo_rd,
    output logic              m1_rfull_n,
    output logic              m2_wfull_n
);
    localparam int SLOT_AB = 0;
    localparam int SLOT_BA = 1;

    port_op_t          a_op;
    port_op_t          b_op;
    logic [DATA_W-1:0] keep_mask;

    logic [NUM_SLOTS-1:0] s_wclk, s_wrst, s_wreq, s_wfull_n;
    logic [NUM_SLOTS-1:0] s_rclk, s_rrst, s_rreq, s_rfull_n;
    logic [DATA_W-1:0]    s_wdat [NUM_SLOTS];
    logic [DATA_W-1:0]    s_rdat [NUM_SLOTS];

    assign a_op = decode_op(a_en, a_wr, a_mb_sel, 1'b1);
    assign b_op = decode_op(b_en, b_wr, b_mb_sel, 1'b0);

    mbx_lane_mask #(.DATA_W(DATA_W)) u_mask (
        .mode (width_mode_e'(b_width)),
        .keep (keep_mask)
    );

    // slot AB: written from port A, read by port B
    assign s_wclk[SLOT_AB] = clk_a;
    assign s_wrst[SLOT_AB] = rst_a;
    assign s_wreq[SLOT_AB] = a_op.mail_wr;
    assign s_wdat[SLOT_AB] = a_wdata & keep_mask;
    assign s_rclk[SLOT_AB] = clk_b;
    assign s_rrst[SLOT_AB] = rst_b;
    assign s_rreq[SLOT_AB] = b_op.mail_rd;

    // slot BA: written from port B, read by port A
    assign s_wclk[SLOT_BA] = clk_b;
    assign s_wrst[SLOT_BA] = rst_b;
    assign s_wreq[SLOT_BA] = b_op.mail_wr;
    assign s_wdat[SLOT_BA] = b_wdata & keep_mask;
    assign s_rclk[SLOT_BA] = clk_a;
    assign s_rrst[SLOT_BA] = rst_a;
    assign s_rreq[SLOT_BA] = a_op.mail_rd;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        mbx_slot #(
            .DATA_W      (DATA_W),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_slot (
            .clk_w    (s_wclk[s]),
            .rst_w    (s_wrst[s]),
            .wr_req   (s_wreq[s]),
            .wr_data  (s_wdat[s]),
            .full_w_n (s_wfull_n[s]),
            .clk_r    (s_rclk[s]),
            .rst_r    (s_rrst[s]),
            .rd_req   (s_rreq[s]),
            .rd_data  (s_rdat[s]),
            .full_r_n (s_rfull_n[s])
        );
    end

    assign m1_wfull_n = s_wfull_n[SLOT_AB];
    assign m1_rfull_n = s_rfull_n[SLOT_AB];
    assign m2_wfull_n = s_wfull_n[SLOT_BA];
    assign m2_rfull_n = s_rfull_n[SLOT_BA];

    assign a_rdata   = a_mb_sel ? s_rdat[SLOT_BA] : '0;
    assign b_rdata   = b_mb_sel ? s_rdat[SLOT_AB] : b_fifo_q;
    assign a_fifo_wr = a_op.queue_go;
    assign b_fifo_rd = b_op.queue_go;
endmodule

// File: rtl/mbx_pair_chk.sv
module mbx_pair_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk_a,
    input logic              rst_a,
    input logic              a_en,
    input logic              a_wr,
    input logic              a_mb_sel,
    input logic [DATA_W-1:0] a_rdata,
    input logic              m1_wfull_n,
    input logic              m2_rfull_n,
    input logic              clk_b,
    input logic              rst_b,
    input logic              b_en,
    input logic              b_wr,
    input logic              b_mb_sel,
    input logic [DATA_W-1:0] b_rdata,
    input logic              b_fifo_rd,
    input logic              m1_rfull_n,
    input logic              m2_wfull_n
);
    a_r1_m1_post: assert property (@(posedge clk_a) disable iff (rst_a)
        (a_en && a_wr && a_mb_sel && m1_wfull_n) |=> !m1_wfull_n);

    a_r2_m1_steady: assert property (@(posedge clk_b) disable iff (rst_b)
        (!m1_rfull_n && $past(!m1_rfull_n) && b_mb_sel && $past(b_mb_sel))
        |-> $stable(b_rdata));

    a_r3_m1_take: assert property (@(posedge clk_b) disable iff (rst_b)
        (b_en && !b_wr && b_mb_sel && !m1_rfull_n) |=> m1_rfull_n);

    a_r5_m2_post: assert property (@(posedge clk_b) disable iff (rst_b)
        (b_en && b_wr && b_mb_sel && m2_wfull_n) |=> !m2_wfull_n);

    a_r5_m2_take: assert property (@(posedge clk_a) disable iff (rst_a)
        (a_en && !a_wr && a_mb_sel && !m2_rfull_n) |=> m2_rfull_n);

    a_r5_m2_steady: assert property (@(posedge clk_a) disable iff (rst_a)
        (!m2_rfull_n && $past(!m2_rfull_n) && a_mb_sel && $past(a_mb_sel))
        |-> $stable(a_rdata));

    a_r8_b_write_no_queue: assert property (@(posedge clk_b) disable iff (rst_b)
        (b_en && b_wr) |-> !b_fifo_rd);

    a_r9_reset_side_a: assert property (@(posedge clk_a) disable iff (rst_a)
        $past(rst_a) |-> (m1_wfull_n && m2_rfull_n));

    a_r9_reset_side_b: assert property (@(posedge clk_b) disable iff (rst_b)
        $past(rst_b) |-> (m1_rfull_n && m2_wfull_n));
endmodule

bind mbx_pair mbx_pair_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mbx_pair_bench.sv
`timescale 1ns/1ps
module mbx_pair_bench;
    localparam int W = 32;

    logic         clk_a = 1'b0, clk_b = 1'b0;
    logic         rst_a, rst_b;
    logic         a_en = 0, a_wr = 0, a_mb_sel = 0;
    logic [W-1:0] a_wdata = '0;
    logic [W-1:0] a_rdata;
    logic         a_fifo_wr, m1_wfull_n, m2_rfull_n;
    logic         b_en = 0, b_wr = 0, b_mb_sel = 0;
    logic [1:0]   b_width = 2'd0;
    logic [W-1:0] b_wdata = '0, b_fifo_q = '0;
    logic [W-1:0] b_rdata;
    logic         b_fifo_rd, m1_rfull_n, m2_wfull_n;

    int n_chk = 0;
    int n_fail = 0;
    logic [W-1:0] q1[$];
    logic [W-1:0] q2[$];

    always #2.5 clk_a = ~clk_a;
    always #3.5 clk_b = ~clk_b;

    mbx_pair #(.DATA_W(W), .SYNC_STAGES(2)) u_mbx_pair (
        .clk_a(clk_a), .rst_a(rst_a), .a_en(a_en), .a_wr(a_wr), .a_mb_sel(a_mb_sel),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .a_fifo_wr(a_fifo_wr),
        .m1_wfull_n(m1_wfull_n), .m2_rfull_n(m2_rfull_n),
        .clk_b(clk_b), .rst_b(rst_b), .b_en(b_en), .b_wr(b_wr), .b_mb_sel(b_mb_sel),
        .b_width(b_width), .b_wdata(b_wdata), .b_fifo_q(b_fifo_q), .b_rdata(b_rdata),
        .b_fifo_rd(b_fifo_rd), .m1_rfull_n(m1_rfull_n), .m2_wfull_n(m2_wfull_n)
    );

    function automatic logic [W-1:0] keep_of(input logic [1:0] m);
        case (m)
            2'd1:    return 32'h0000_FFFF;
            2'd2:    return 32'h0000_00FF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: port A deposit into mailbox 1
    task automatic a_post(input logic [W-1:0] d);
        @(posedge clk_a); #1;
        if (m1_wfull_n) q1.push_back(d & keep_of(b_width));
        a_en = 1; a_wr = 1; a_mb_sel = 1; a_wdata = d;
        @(posedge clk_a); #1;
        a_en = 0; a_mb_sel = 0;
    endtask

    // driver: port B deposit into mailbox 2
    task automatic b_post(input logic [W-1:0] d);
        @(posedge clk_b); #1;
        if (m2_wfull_n) q2.push_back(d & keep_of(b_width));
        b_en = 1; b_wr = 1; b_mb_sel = 1; b_wdata = d;
        @(posedge clk_b); #1;
        b_en = 0; b_wr = 0; b_mb_sel = 0;
    endtask

    // monitor: port B collects mailbox 1 and compares with the queue
    task automatic b_collect();
        logic [W-1:0] exp;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk_b); #1;
            if (!m1_rfull_n) i = 4;
        end
        check(!m1_rfull_n, "R2 m1_rfull_n low", {31'd0, m1_rfull_n}, '0);
        b_mb_sel = 1; #1;
        exp = (q1.size() > 0) ? q1.pop_front() : '0;
        check(b_rdata == exp, "R2 mailbox 1 word", b_rdata, exp);
        b_en = 1; b_wr = 0;
        @(posedge clk_b); #1;
        b_en = 0; b_mb_sel = 0;
        check(m1_rfull_n, "R3 m1_rfull_n high after read", {31'd0, m1_rfull_n}, 1);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk_a); #1;
            if (m1_wfull_n) i = 4;
        end
        check(m1_wfull_n, "R3 m1_wfull_n back high", {31'd0, m1_wfull_n}, 1);
    endtask

    // monitor: port A collects mailbox 2 and compares with the queue
    task automatic a_collect();
        logic [W-1:0] exp;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk_a); #1;
            if (!m2_rfull_n) i = 4;
        end
        check(!m2_rfull_n, "R5 m2_rfull_n low", {31'd0, m2_rfull_n}, '0);
        a_mb_sel = 1; #1;
        exp = (q2.size() > 0) ? q2.pop_front() : '0;
        check(a_rdata == exp, "R6 mailbox 2 word", a_rdata, exp);
        a_en = 1; a_wr = 0;
        @(posedge clk_a); #1;
        a_en = 0; a_mb_sel = 0;
        check(m2_rfull_n, "R5 m2_rfull_n high after read", {31'd0, m2_rfull_n}, 1);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk_b); #1;
            if (m2_wfull_n) i = 4;
        end
        check(m2_wfull_n, "R5 m2_wfull_n back high", {31'd0, m2_wfull_n}, 1);
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_a = 1; rst_b = 1;
        repeat (4) @(posedge clk_b);
        @(posedge clk_a); #1 rst_a = 0;
        @(posedge clk_b); #1 rst_b = 0;
        #1;
        // R9 reset state
        check(m1_wfull_n && m1_rfull_n && m2_wfull_n && m2_rfull_n, "R9 flags high",
              {28'd0, m1_wfull_n, m1_rfull_n, m2_wfull_n, m2_rfull_n}, 32'hF);
        b_mb_sel = 1; a_mb_sel = 1; #1;
        check(b_rdata == '0, "R9 mailbox 1 cleared", b_rdata, '0);
        check(a_rdata == '0, "R9 mailbox 2 cleared", a_rdata, '0);
        b_mb_sel = 0; a_mb_sel = 0;

        // R7 queue output path, R6 unselected read is zero
        b_fifo_q = 32'h1357_9BDF; #1;
        check(b_rdata == 32'h1357_9BDF, "R7 queue data on port B", b_rdata, 32'h1357_9BDF);
        check(a_rdata == '0, "R6 port A unselected", a_rdata, '0);

        // R8 strobes (changed between edges)
        @(posedge clk_a); #1;
        a_en = 1; a_wr = 1; a_mb_sel = 0; #0.5;
        check(a_fifo_wr, "R8 a_fifo_wr on queue write", {31'd0, a_fifo_wr}, 1);
        a_wr = 0; #0.5;
        check(!a_fifo_wr, "R8 a_fifo_wr off on read", {31'd0, a_fifo_wr}, 0);
        a_en = 0;
        @(posedge clk_b); #1;
        b_en = 1; b_wr = 0; b_mb_sel = 0; #0.5;
        check(b_fifo_rd, "R8 b_fifo_rd on queue read", {31'd0, b_fifo_rd}, 1);
        b_wr = 1; #0.5;
        check(!b_fifo_rd, "R8 b write no strobe", {31'd0, b_fifo_rd}, 0);
        b_en = 0; b_wr = 0;

        // R11 read of an empty mailbox 1
        @(posedge clk_b); #1;
        b_en = 1; b_wr = 0; b_mb_sel = 1;
        @(posedge clk_b); #1;
        b_en = 0; b_mb_sel = 0;
        check(m1_rfull_n, "R11 reader flag unchanged", {31'd0, m1_rfull_n}, 1);
        repeat (5) @(posedge clk_a); #1;
        check(m1_wfull_n, "R11 writer flag unchanged", {31'd0, m1_wfull_n}, 1);

        // R1, R4, R2, R3 on mailbox 1
        a_post(32'hA5A5_1234);
        check(!m1_wfull_n, "R1 m1_wfull_n low after write", {31'd0, m1_wfull_n}, 0);
        a_post(32'hDEAD_BEEF);   // R4: dropped, queue unchanged
        b_collect();

        // R5, R6, R4 on mailbox 2
        b_post(32'h0BAD_F00D);
        check(!m2_wfull_n, "R5 m2_wfull_n low after write", {31'd0, m2_wfull_n}, 0);
        b_post(32'h7777_7777);   // R4: dropped
        a_collect();

        // R10 width trimming
        b_width = 2'd1;
        a_post(32'hFFFF_ABCD);
        b_collect();
        b_width = 2'd2;
        b_post(32'h1234_56EF);
        a_collect();
        b_width = 2'd3;
        a_post(32'hCAFE_0001);
        b_collect();
        b_width = 2'd0;

        // scoreboard stream in both directions
        for (int k = 0; k < 4; k++) begin
            a_post(32'h1000_0000 + k * 32'h0101_0101);
            b_post(32'h2000_0000 + k * 32'h0011_0011);
            b_collect();
            a_collect();
        end
        check(q1.size() == 0 && q2.size() == 0, "R2 scoreboard drained",
              q1.size() + q2.size(), '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule